// File: doc/BRIEF.md
# 1-Wire Passive Bus Monitor

This block listens to a single 1-Wire data line and reports what happens on it, without ever driving the line. The raw line passes through a synchronizer. A timing engine then measures low periods and sample offsets in units of a configurable time base. From these it recovers three link events: data bits, bus resets and the presence response that follows a reset.

A second stage collects data bits into bytes. The first byte after each bus reset is the ROM function command. That byte is classified into one of a small set of command classes and reported once. All later bytes in the same transaction are still reported as bytes, but they are not classified again until the next reset. Every event leaves the block as a one-cycle strobe, with its value held on a companion output until the next event of the same kind.

Top module: `ow_bus_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every strobe is low and `bit_val`, `pres_found`, `byte_val` and `cmd_cls` are zero.
- R2: The line is sampled `TB_CYC` clocks after a synchronized falling edge. `bit_stb` pulses `TB_CYC`+2 clocks after the first clock edge that captures the line low, and `bit_val` carries the sampled level.
- R3: After a sampled 1 the monitor accepts the next falling edge at once. After a sampled 0 it waits for the line to rise before it accepts a new slot.
- R4: A low period of at most 8·`TB_CYC` clocks that ends on a rise is a normal 0 bit. It produces no `rst_stb`.
- R5: A low period longer than 8·`TB_CYC` clocks produces `rst_stb` 2 clocks after the first clock edge that captures the line high. Such a pulse also yields a 0 bit at its own sample point.
- R6: After a reset, the line is sampled floor(5·`TB_CYC`/2) clocks after the rise. `pres_stb` pulses that many clocks plus 2 after the first edge that captured the rise. `pres_found` is 1 for a low sample (device present) and 0 for a high sample.
- R7: Data bits are gathered least-significant bit first. `byte_stb` pulses one clock after the `bit_stb` of every eighth bit counted from the last reset, and `byte_val` holds the assembled byte.
- R8: The first byte after a reset raises `cmd_stb` together with `byte_stb`. `cmd_cls` is 1 for 0x33 or 0x0F (read ROM), 2 for 0xCC (skip ROM), 3 for 0x55 (match ROM), 4 for 0xF0 (search ROM), 5 for 0x3C (overdrive skip), 6 for 0x69 (overdrive match).
- R9: A first byte that matches none of the codes in R8 gives `cmd_cls` = 7.
- R10: Bytes after the command byte, and bytes before any reset, raise `byte_stb` without `cmd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Raw 1-Wire bus level (asynchronous) |
| bit_stb | output | 1 | One-cycle pulse per recovered data bit |
| bit_val | output | 1 | Level of the last recovered bit |
| rst_stb | output | 1 | One-cycle pulse per detected bus reset |
| pres_stb | output | 1 | One-cycle pulse when the presence sample is taken |
| pres_found | output | 1 | 1 when a device answered the last reset |
| byte_stb | output | 1 | One-cycle pulse per completed byte |
| byte_val | output | 8 | Last completed byte |
| cmd_stb | output | 1 | One-cycle pulse for the first byte after a reset |
| cmd_cls | output | 3 | Class of the last command byte (R8, R9) |

## Verification
The bench counts clock edges and drives the line between edges. It records, for each line change, the cycle number in which the change first becomes visible. A data bit is then due `TB_CYC`+3 counted cycles after the falling drive, a reset 3 cycles after the rising drive, and the presence strobe floor(5·`TB_CYC`/2)+3 cycles after it. The byte and command strobes are due exactly one cycle after the eighth bit strobe. A monitor on the opposite clock edge stamps every strobe with its cycle number, and each scenario task compares those stamps and the held values against these offsets. The 8·`TB_CYC` limit is tested at exactly that length and one cycle longer.

// File: rtl/owmon_pkg.sv
package owmon_pkg;

   typedef enum logic [2:0] {
      CLS_NONE     = 3'd0,
      CLS_READ     = 3'd1,
      CLS_SKIP     = 3'd2,
      CLS_MATCH    = 3'd3,
      CLS_SEARCH   = 3'd4,
      CLS_OD_SKIP  = 3'd5,
      CLS_OD_MATCH = 3'd6,
      CLS_UNKNOWN  = 3'd7
   } rom_cls_e;

   typedef enum logic [1:0] {
      LS_IDLE   = 2'd0,
      LS_SAMPLE = 2'd1,
      LS_LOW    = 2'd2,
      LS_PRES   = 2'd3
   } link_st_e;

   function automatic rom_cls_e classify_rom(input logic [7:0] code);
      rom_cls_e c;
      case (code)
         8'h33, 8'h0F: c = CLS_READ;
         8'hCC:        c = CLS_SKIP;
         8'h55:        c = CLS_MATCH;
         8'hF0:        c = CLS_SEARCH;
         8'h3C:        c = CLS_OD_SKIP;
         8'h69:        c = CLS_OD_MATCH;
         default:      c = CLS_UNKNOWN;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   output logic lvl,
   output logic fall,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ow_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;
   logic              last;

   // Idle bus level is high, so the chain resets to ones.
   always_ff @(posedge clk) begin
      if (rst) begin
         sh   <= '1;
         last <= 1'b1;
      end else begin
         sh   <= {sh[STAGES-2:0], line_in};
         last <= sh[STAGES-1];
      end
   end

   assign lvl  = sh[STAGES-1];
   assign fall = last & ~sh[STAGES-1];
   assign rise = ~last & sh[STAGES-1];

endmodule

// File: rtl/ow_link_fsm.sv
module ow_link_fsm
   import owmon_pkg::*;
#(
   parameter int TB_CYC = 30
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   input  logic fall,
   input  logic rise,
   output logic bit_stb,
   output logic bit_val,
   output logic rst_stb,
   output logic pres_stb,
   output logic pres_found
);

   localparam int RST_CYC  = 8 * TB_CYC;
   localparam int PRES_CYC = (5 * TB_CYC) / 2;
   localparam int CW       = $clog2(RST_CYC + 1);

   localparam logic [CW-1:0] SAMP_AT = CW'(TB_CYC - 1);
   localparam logic [CW-1:0] PRES_AT = CW'(PRES_CYC - 1);
   localparam logic [CW-1:0] RST_LIM = CW'(RST_CYC);

   generate
      if (TB_CYC < 4) begin : g_bad_tb
         $error("ow_link_fsm: TB_CYC must be at least 4");
      end
   endgenerate

   link_st_e        st;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= LS_IDLE;
         cnt        <= '0;
         bit_stb    <= 1'b0;
         bit_val    <= 1'b0;
         rst_stb    <= 1'b0;
         pres_stb   <= 1'b0;
         pres_found <= 1'b0;
      end else begin
         bit_stb  <= 1'b0;
         rst_stb  <= 1'b0;
         pres_stb <= 1'b0;
         // Saturating cycle counter; the limit is the reset threshold.
         if (cnt != RST_LIM) cnt <= cnt + 1'b1;
         case (st)
            LS_IDLE: begin
               if (fall) begin
                  st  <= LS_SAMPLE;
                  cnt <= '0;
               end
            end
            LS_SAMPLE: begin
               if (cnt == SAMP_AT) begin
                  bit_stb <= 1'b1;
                  bit_val <= lvl;
                  st      <= lvl ? LS_IDLE : LS_LOW;
               end
            end
            LS_LOW: begin
               if (rise) begin
                  if (cnt >= RST_LIM) begin
                     rst_stb <= 1'b1;
                     st      <= LS_PRES;
                     cnt     <= '0;
                  end else begin
                     st <= LS_IDLE;
                  end
               end
            end
            LS_PRES: begin
               if (cnt == PRES_AT) begin
                  pres_stb   <= 1'b1;
                  pres_found <= ~lvl;
                  st         <= lvl ? LS_IDLE : LS_LOW;
                  cnt        <= '0;
               end
            end
            default: st <= LS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ow_rom_cmd.sv
module ow_rom_cmd
   import owmon_pkg::*;
#(
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bit_stb,
   input  logic       bit_val,
   input  logic       rst_stb,
   output logic       byte_stb,
   output logic [7:0] byte_val,
   output logic       cmd_stb,
   output logic [2:0] cmd_cls
);

   logic [7:0] sh;
   logic [7:0] sh_nx;
   logic [2:0] nbit;
   logic       armed;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sh_nx = {bit_val, sh[7:1]};
      end else begin : g_msb
         assign sh_nx = {sh[6:0], bit_val};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh       <= '0;
         nbit     <= '0;
         armed    <= 1'b0;
         byte_stb <= 1'b0;
         byte_val <= '0;
         cmd_stb  <= 1'b0;
         cmd_cls  <= CLS_NONE;
      end else begin
         byte_stb <= 1'b0;
         cmd_stb  <= 1'b0;
         if (rst_stb) begin
            sh    <= '0;
            nbit  <= '0;
            armed <= 1'b1;
         end else if (bit_stb) begin
            sh   <= sh_nx;
            nbit <= nbit + 1'b1;
            if (nbit == 3'd7) begin
               byte_stb <= 1'b1;
               byte_val <= sh_nx;
               if (armed) begin
                  cmd_stb <= 1'b1;
                  cmd_cls <= classify_rom(sh_nx);
                  armed   <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/ow_bus_monitor.sv
module ow_bus_monitor #(
   parameter int TB_CYC      = 30,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       line_in,
   output logic       bit_stb,
   output logic       bit_val,
   output logic       rst_stb,
   output logic       pres_stb,
   output logic       pres_found,
   output logic       byte_stb,
   output logic [7:0] byte_val,
   output logic       cmd_stb,
   output logic [2:0] cmd_cls
);

   logic s_lvl, s_fall, s_rise;

   ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .line_in(line_in),
      .lvl    (s_lvl),
      .fall   (s_fall),
      .rise   (s_rise)
   );

   ow_link_fsm #(.TB_CYC(TB_CYC)) u_link (
      .clk       (clk),
      .rst       (rst),
      .lvl       (s_lvl),
      .fall      (s_fall),
      .rise      (s_rise),
      .bit_stb   (bit_stb),
      .bit_val   (bit_val),
      .rst_stb   (rst_stb),
      .pres_stb  (pres_stb),
      .pres_found(pres_found)
   );

   ow_rom_cmd #(.LSB_FIRST(LSB_FIRST)) u_cmd (
      .clk     (clk),
      .rst     (rst),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .rst_stb (rst_stb),
      .byte_stb(byte_stb),
      .byte_val(byte_val),
      .cmd_stb (cmd_stb),
      .cmd_cls (cmd_cls)
   );

endmodule

// File: rtl/ow_bus_monitor_chk.sv
module ow_bus_monitor_chk (
   input logic       clk,
   input logic       rst,
   input logic       bit_stb,
   input logic       rst_stb,
   input logic       pres_stb,
   input logic       byte_stb,
   input logic       cmd_stb
);

   logic pres_pend;
   logic cmd_pend;

   always_ff @(posedge clk) begin
      if (rst) begin
         pres_pend <= 1'b0;
         cmd_pend  <= 1'b0;
      end else begin
         if (rst_stb)       pres_pend <= 1'b1;
         else if (pres_stb) pres_pend <= 1'b0;
         if (rst_stb)       cmd_pend  <= 1'b1;
         else if (cmd_stb)  cmd_pend  <= 1'b0;
      end
   end

   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !(bit_stb || rst_stb || pres_stb || byte_stb || cmd_stb));

   p_one_link_event_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0({bit_stb, rst_stb, pres_stb}));

   p_pres_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
      pres_stb |-> pres_pend);

   p_byte_after_bit_r7: assert property (@(posedge clk) disable iff (rst)
      byte_stb |-> $past(bit_stb));

   p_cmd_once_r10: assert property (@(posedge clk) disable iff (rst)
      cmd_stb |-> (cmd_pend && byte_stb));

endmodule

bind ow_bus_monitor ow_bus_monitor_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .bit_stb (bit_stb),
   .rst_stb (rst_stb),
   .pres_stb(pres_stb),
   .byte_stb(byte_stb),
   .cmd_stb (cmd_stb)
);

// File: tb/tb_ow_bus_monitor.sv
module tb_ow_bus_monitor;

   localparam int TB   = 16;
   localparam int PRES = (5 * TB) / 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       line = 1'b1;
   logic       bit_stb, bit_val, rst_stb, pres_stb, pres_found;
   logic       byte_stb, cmd_stb;
   logic [7:0] byte_val;
   logic [2:0] cmd_cls;

   always #2 clk = ~clk;

   ow_bus_monitor #(.TB_CYC(TB)) dut (
      .clk       (clk),
      .rst       (rst),
      .line_in   (line),
      .bit_stb   (bit_stb),
      .bit_val   (bit_val),
      .rst_stb   (rst_stb),
      .pres_stb  (pres_stb),
      .pres_found(pres_found),
      .byte_stb  (byte_stb),
      .byte_val  (byte_val),
      .cmd_stb   (cmd_stb),
      .cmd_cls   (cmd_cls)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_checks = 0, n_fail = 0;
   int n_bit = 0, n_rst = 0, n_pres = 0, n_byte = 0, n_cmd = 0;
   int bit_cyc, rst_cyc, pres_cyc, byte_cyc, cmd_cyc;
   int last_bit, last_pres, last_byte, last_cls;

   always @(negedge clk) begin
      if (!rst) begin
         if (bit_stb)  begin n_bit++;  bit_cyc = cyc;  last_bit = int'(bit_val); end
         if (rst_stb)  begin n_rst++;  rst_cyc = cyc; end
         if (pres_stb) begin n_pres++; pres_cyc = cyc; last_pres = int'(pres_found); end
         if (byte_stb) begin n_byte++; byte_cyc = cyc; last_byte = int'(byte_val); end
         if (cmd_stb)  begin n_cmd++;  cmd_cyc = cyc;  last_cls = int'(cmd_cls); end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic low_pulse(int n, output int c, output int d);
      @(negedge clk);
      line = 1'b0; c = cyc;
      repeat (n) @(negedge clk);
      line = 1'b1; d = cyc;
   endtask

   task automatic send_bit(bit b);
      int c, d;
      if (b) begin low_pulse(2, c, d);      idle(4 * TB); end
      else   begin low_pulse(3 * TB, c, d); idle(TB);     end
   endtask

   task automatic send_byte(logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic bus_reset(bit dev, output int d);
      int c;
      low_pulse(8 * TB + 1, c, d);
      if (dev) begin
         idle(TB);     line = 1'b0;
         idle(3 * TB); line = 1'b1;
      end else begin
         idle(4 * TB);
      end
      idle(TB);
   endtask

   task automatic t_reset_state();
      idle(1);
      chk("R1", "strobes", int'({bit_stb, rst_stb, pres_stb, byte_stb, cmd_stb}), 0);
      chk("R1", "values", int'({bit_val, pres_found, byte_val, cmd_cls}), 0);
   endtask

   task automatic t_bit_one();
      int c, d, nb;
      nb = n_bit;
      low_pulse(2, c, d); idle(4 * TB);
      chk("R2", "bit1 count", n_bit, nb + 1);
      chk("R2", "bit1 value", last_bit, 1);
      chk("R2", "bit1 cycle", bit_cyc, c + TB + 3);
      low_pulse(2, c, d); idle(4 * TB);
      chk("R3", "back-to-back bit after 1", n_bit, nb + 2);
      chk("R3", "second bit cycle", bit_cyc, c + TB + 3);
   endtask

   task automatic t_bit_zero();
      int c, d, nb, nr;
      nb = n_bit; nr = n_rst;
      low_pulse(3 * TB, c, d); idle(TB);
      chk("R2", "bit0 value", last_bit, 0);
      chk("R2", "bit0 cycle", bit_cyc, c + TB + 3);
      chk("R4", "no reset on 3TB low", n_rst, nr);
      low_pulse(2, c, d); idle(4 * TB);
      chk("R3", "slot after rise", n_bit, nb + 2);
   endtask

   task automatic t_boundary_low();
      int c, d, nb, nr;
      nb = n_bit; nr = n_rst;
      low_pulse(8 * TB, c, d); idle(2 * TB);
      chk("R4", "no reset at 8TB low", n_rst, nr);
      chk("R4", "bit value at 8TB low", last_bit, 0);
      low_pulse(2, c, d); idle(4 * TB);
      chk("R4", "idle after long 0 bit", n_bit, nb + 2);
      chk("R10", "no command before reset", n_cmd, 0);
   endtask

   task automatic t_reset_presence();
      int c, d, nb, nr, np;
      nb = n_bit; nr = n_rst; np = n_pres;
      low_pulse(8 * TB + 1, c, d);
      idle(TB); line = 1'b0;
      idle(3 * TB); line = 1'b1;
      idle(TB);
      chk("R5", "reset count", n_rst, nr + 1);
      chk("R5", "reset cycle", rst_cyc, d + 3);
      chk("R5", "zero bit inside reset", n_bit, nb + 1);
      chk("R5", "zero bit cycle", bit_cyc, c + TB + 3);
      chk("R6", "presence count", n_pres, np + 1);
      chk("R6", "presence cycle", pres_cyc, d + PRES + 3);
      chk("R6", "device present", last_pres, 1);
   endtask

   task automatic t_no_device();
      int d, nb;
      bus_reset(1'b0, d);
      chk("R6", "presence cycle no device", pres_cyc, d + PRES + 3);
      chk("R6", "no device", last_pres, 0);
      nb = n_bit;
      send_bit(1'b1);
      chk("R6", "slot after empty presence", n_bit, nb + 1);
   endtask

   task automatic t_command(logic [7:0] code, int cls, string req);
      int d, nby, nc;
      bus_reset(1'b1, d);
      nby = n_byte; nc = n_cmd;
      send_byte(code);
      chk("R7", "byte count", n_byte, nby + 1);
      chk("R7", "byte value", last_byte, int'(code));
      chk("R7", "byte one cycle after bit", byte_cyc, bit_cyc + 1);
      chk(req, "command count", n_cmd, nc + 1);
      chk(req, "command with byte", cmd_cyc, byte_cyc);
      chk(req, "command class", last_cls, cls);
   endtask

   task automatic t_after_cmd();
      int nby, nc;
      nby = n_byte; nc = n_cmd;
      send_byte(8'h33);
      chk("R10", "second byte seen", n_byte, nby + 1);
      chk("R10", "second byte value", last_byte, 8'h33);
      chk("R10", "no second command", n_cmd, nc);
      chk("R10", "class held", last_cls, 3);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      idle(5);
      rst = 1'b0;
      t_reset_state();
      t_bit_one();
      t_bit_zero();
      t_boundary_low();
      t_reset_presence();
      t_no_device();
      t_command(8'h33, 1, "R8");
      t_command(8'h0F, 1, "R8");
      t_command(8'hCC, 2, "R8");
      t_command(8'hF0, 4, "R8");
      t_command(8'h3C, 5, "R8");
      t_command(8'h69, 6, "R8");
      t_command(8'hA5, 7, "R9");
      t_command(8'h55, 3, "R8");
      t_after_cmd();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule